// File: doc/BRIEF.md
# Kernel Mode Guard

This block sits beside a processor core and watches every instruction fetch and data access the core makes, together with the overlay page that goes with each address. It tracks whether the core runs in a privileged kernel mode or in user mode. It admits the core to kernel mode at exactly one entry point. It lets a kernel routine be interrupted into a user handler, and lets that handler call the kernel once more, but no deeper. It checks that the return from such an interrupt lands on the precise address and overlay that were interrupted.

Any breach of these rules does three things. It raises a chip-reset request. It starts an erase sequence that walks the protected storage one word per cycle. It records which rule fired. While the sequence runs, the core's inputs are ignored and the debug port is refused. The core reports each fetch with a kind code, so the guard can tell a sequential step, a jump, a call, an interrupt return and an interrupt vector apart.

Top module: `kmode_guard`

## Requirements
- R1: After reset the guard is in user mode, `viol_reset` and `erase_en` are low, `cause_valid` is low, `irq_allow` is high and `emu_gnt` follows `emu_req`.
- R2: `fetch_kind` codes are 0 sequential, 1 jump, 2 call, 3 interrupt return, 4 interrupt vector. Kernel mode is entered from user mode only by a fetch of kind 0, 1 or 2 at address 0x2000 with overlay 0xF. Other overlays and other kinds at that address do not enter.
- R3: In user mode, a fetch at 0x2001..0x3FFF with overlay 0xC..0xF is a violation with cause 1. The same addresses with overlay below 0xC are not.
- R4: In user mode, a data access at 0x0000..0x17FF with overlay 0xF is a violation with cause 2. Other overlays, higher addresses, and any access made in kernel mode are not.
- R5: In kernel mode, a fetch of kind 1, 2 or 3 to an address outside kernel space returns the guard to user mode. Kernel space is 0x2000..0x3FFF with overlay 0xC..0xF. A sequential fetch never leaves kernel mode.
- R6: `emu_gnt` is low whenever the guard is in kernel mode or erasing.
- R7: In kernel mode, a write with `claim_we` sets or clears the claim on one 1K-word block of program (`claim_pm`=1) or data (`claim_pm`=0) space, with `claim_blk` equal to address bits 13:10. A user access to a claimed block is a violation with cause 3. Claim writes made in user mode are ignored.
- R8: An interrupt vector fetch taken in kernel mode saves `int_addr`/`int_ovl`. The mode then follows the vector's space. Once the handler is back in user mode, an interrupt return to the saved address and overlay re-enters kernel mode. An interrupt return to any other target is a violation with cause 5.
- R9: While in a nested kernel call, an interrupt vector outside kernel space is a violation with cause 4. A vector inside kernel space is accepted with no change.
- R10: In kernel mode, a write with `inh_we` sets the interrupt-inhibit bit, and `irq_allow` then falls. The bit clears whenever the guard leaves kernel mode.
- R11: The cycle after a violation, `viol_reset` and `erase_en` rise for exactly ERASE_WORDS cycles with `erase_addr` stepping 0, 1, ... ERASE_WORDS-1. After that the guard is in user mode with claims cleared.
- R12: `cause` reads 0 and `cause_valid` is low while erasing. After the erase, `cause_valid` is high and `cause` holds the code of the first violation since reset, even if further violations follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_kind | input | 3 | Fetch kind code (see R2) |
| fetch_addr | input | 14 | Program address fetched |
| fetch_ovl | input | 4 | Program overlay of the fetch |
| int_addr | input | 14 | Interrupted address, valid with a vector fetch |
| int_ovl | input | 4 | Interrupted overlay, valid with a vector fetch |
| dm_valid | input | 1 | A data access is presented this cycle |
| dm_addr | input | 14 | Data address |
| dm_ovl | input | 4 | Data overlay |
| claim_we | input | 1 | Claim write strobe |
| claim_pm | input | 1 | 1 selects program space, 0 data space |
| claim_blk | input | 4 | 1K-word block index |
| claim_set | input | 1 | 1 claims, 0 releases |
| inh_we | input | 1 | Interrupt-inhibit write strobe |
| inh_val | input | 1 | Interrupt-inhibit value |
| emu_req | input | 1 | Emulator bus request |
| kernel_mode | output | 1 | Guard is in kernel mode |
| emu_gnt | output | 1 | Emulator bus grant |
| irq_allow | output | 1 | Core may accept interrupts |
| viol_reset | output | 1 | Chip-reset request |
| erase_en | output | 1 | Erase strobe |
| erase_addr | output | $clog2(ERASE_WORDS) | Word being erased |
| cause_valid | output | 1 | Recorded cause is readable |
| cause | output | 3 | 1 program, 2 data, 3 claim, 4 nested vector, 5 bad return |

## Verification
The bench builds the guard with ERASE_WORDS set to 6 and keeps every other parameter at its default. The short erase lets each violation scenario walk the whole sequence, including its last word and the first cycle after it. The default 14-bit addresses and 4-bit overlays put both ends of every protected range within reach: 0x2000 versus 0x2001, 0x3FFF, 0x17FF versus 0x1800, and overlay 0xB versus 0xC. Claimed 1K blocks can be probed at both their first and their last word.

// File: rtl/kmg_pkg.sv
package kmg_pkg;
    typedef enum logic [2:0] {
        FK_SEQ  = 3'd0,
        FK_JUMP = 3'd1,
        FK_CALL = 3'd2,
        FK_RTI  = 3'd3,
        FK_IRQ  = 3'd4
    } fetch_kind_e;

    typedef enum logic [2:0] {
        CZ_NONE  = 3'd0,
        CZ_PM    = 3'd1,
        CZ_DM    = 3'd2,
        CZ_CLAIM = 3'd3,
        CZ_NEST  = 3'd4,
        CZ_RTI   = 3'd5
    } cause_e;
endpackage

// File: rtl/kmg_addr_decode.sv
module kmg_addr_decode #(
    parameter int AW          = 14,
    parameter int OVLW        = 4,
    parameter int ENTRY_ADDR  = 'h2000,
    parameter int KOVL        = 'hF,
    parameter int PM_KEND     = 'h3FFF,
    parameter int PM_KOVL_MIN = 'hC,
    parameter int DM_KEND     = 'h17FF,
    parameter int DM_KOVL     = 'hF
) (
    input  logic [AW-1:0]   f_addr,
    input  logic [OVLW-1:0] f_ovl,
    input  logic [AW-1:0]   d_addr,
    input  logic [OVLW-1:0] d_ovl,
    output logic            f_entry,
    output logic            f_kernel,
    output logic            f_kspace,
    output logic            d_kspace
);
    localparam logic [AW:0]     L_ENTRY = (AW+1)'(ENTRY_ADDR);
    localparam logic [AW:0]     L_PMEND = (AW+1)'(PM_KEND);
    localparam logic [AW:0]     L_DMEND = (AW+1)'(DM_KEND);
    localparam logic [OVLW-1:0] L_KOVL  = OVLW'(KOVL);
    localparam logic [OVLW-1:0] L_PMOVL = OVLW'(PM_KOVL_MIN);
    localparam logic [OVLW-1:0] L_DMOVL = OVLW'(DM_KOVL);

    logic [AW:0] fa_w;
    logic [AW:0] da_w;
    logic        f_ovl_ok;

    always_comb begin
        fa_w     = {1'b0, f_addr};
        da_w     = {1'b0, d_addr};
        f_ovl_ok = (f_ovl >= L_PMOVL);
        f_entry  = (fa_w == L_ENTRY) && (f_ovl == L_KOVL);
        f_kernel = f_ovl_ok && (fa_w >= L_ENTRY) && (fa_w <= L_PMEND);
        f_kspace = f_ovl_ok && (fa_w > L_ENTRY) && (fa_w <= L_PMEND);
        d_kspace = (d_ovl == L_DMOVL) && (da_w <= L_DMEND);
    end
endmodule

// File: rtl/kmg_claim_map.sv
module kmg_claim_map #(
    parameter int AW   = 14,
    parameter int BLKW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic              sel_pm,
    input  logic [AW-BLKW-1:0] blk,
    input  logic              val,
    input  logic [AW-1:0]     f_addr,
    input  logic [AW-1:0]     d_addr,
    output logic              f_hit,
    output logic              d_hit
);
    localparam int NBW  = AW - BLKW;
    localparam int NBLK = 1 << NBW;

    logic [NBLK-1:0] pm_d, pm_q;
    logic [NBLK-1:0] dm_d, dm_q;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic hit_w;
        assign hit_w   = we && (blk == NBW'(g));
        assign pm_d[g] = clr ? 1'b0 : ((hit_w && sel_pm)  ? val : pm_q[g]);
        assign dm_d[g] = clr ? 1'b0 : ((hit_w && !sel_pm) ? val : dm_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q <= '0;
            dm_q <= '0;
        end else begin
            pm_q <= pm_d;
            dm_q <= dm_d;
        end
    end

    assign f_hit = pm_q[f_addr[AW-1:BLKW]];
    assign d_hit = dm_q[d_addr[AW-1:BLKW]];
endmodule

// File: rtl/kmg_erase_seq.sv
module kmg_erase_seq #(
    parameter int ERASE_WORDS = 64,
    parameter int EW          = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [EW-1:0] addr
);
    localparam logic [EW-1:0] LAST = EW'(ERASE_WORDS - 1);

    typedef struct packed {
        logic          busy;
        logic [EW-1:0] cnt;
    } es_t;

    es_t es_d, es_q;

    always_comb begin
        es_d = es_q;
        if (es_q.busy) begin
            if (es_q.cnt == LAST) begin
                es_d.busy = 1'b0;
                es_d.cnt  = '0;
            end else begin
                es_d.cnt = es_q.cnt + 1'b1;
            end
        end else if (start) begin
            es_d.busy = 1'b1;
            es_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    assign busy = es_q.busy;
    assign addr = es_q.cnt;
endmodule

// File: rtl/kmode_guard.sv
module kmode_guard
    import kmg_pkg::*;
#(
    parameter int AW          = 14,
    parameter int OVLW        = 4,
    parameter int BLKW        = 10,
    parameter int ERASE_WORDS = 64,
    parameter int ENTRY_ADDR  = 'h2000,
    parameter int KOVL        = 'hF,
    parameter int PM_KEND     = 'h3FFF,
    parameter int PM_KOVL_MIN = 'hC,
    parameter int DM_KEND     = 'h17FF,
    parameter int DM_KOVL     = 'hF,
    localparam int EW         = (ERASE_WORDS > 1) ? $clog2(ERASE_WORDS) : 1,
    localparam int NBW        = AW - BLKW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [2:0]      fetch_kind,
    input  logic [AW-1:0]   fetch_addr,
    input  logic [OVLW-1:0] fetch_ovl,
    input  logic [AW-1:0]   int_addr,
    input  logic [OVLW-1:0] int_ovl,
    input  logic            dm_valid,
    input  logic [AW-1:0]   dm_addr,
    input  logic [OVLW-1:0] dm_ovl,
    input  logic            claim_we,
    input  logic            claim_pm,
    input  logic [NBW-1:0]  claim_blk,
    input  logic            claim_set,
    input  logic            inh_we,
    input  logic            inh_val,
    input  logic            emu_req,
    output logic            kernel_mode,
    output logic            emu_gnt,
    output logic            irq_allow,
    output logic            viol_reset,
    output logic            erase_en,
    output logic [EW-1:0]   erase_addr,
    output logic            cause_valid,
    output logic [2:0]      cause
);
    typedef struct packed {
        logic            kmode;
        logic            nest;
        logic            inh;
        logic [AW-1:0]   sv_addr;
        logic [OVLW-1:0] sv_ovl;
        logic [2:0]      cause;
    } st_t;

    st_t st_d, st_q;

    logic        f_entry, f_kernel, f_kspace, d_kspace;
    logic        f_claimed, d_claimed;
    logic        busy;
    logic        viol;
    logic        claim_wr;
    cause_e      code;
    fetch_kind_e fk;
    logic        is_branch, enter, rti_back, rti_ok;

    kmg_addr_decode #(
        .AW(AW), .OVLW(OVLW), .ENTRY_ADDR(ENTRY_ADDR), .KOVL(KOVL),
        .PM_KEND(PM_KEND), .PM_KOVL_MIN(PM_KOVL_MIN),
        .DM_KEND(DM_KEND), .DM_KOVL(DM_KOVL)
    ) i_dec (
        .f_addr(fetch_addr), .f_ovl(fetch_ovl),
        .d_addr(dm_addr), .d_ovl(dm_ovl),
        .f_entry(f_entry), .f_kernel(f_kernel),
        .f_kspace(f_kspace), .d_kspace(d_kspace)
    );

    kmg_claim_map #(.AW(AW), .BLKW(BLKW)) i_claim (
        .clk(clk), .rst_n(rst_n), .clr(viol), .we(claim_wr),
        .sel_pm(claim_pm), .blk(claim_blk), .val(claim_set),
        .f_addr(fetch_addr), .d_addr(dm_addr),
        .f_hit(f_claimed), .d_hit(d_claimed)
    );

    kmg_erase_seq #(.ERASE_WORDS(ERASE_WORDS), .EW(EW)) i_erase (
        .clk(clk), .rst_n(rst_n), .start(viol),
        .busy(busy), .addr(erase_addr)
    );

    always_comb begin
        fk        = fetch_kind_e'(fetch_kind);
        is_branch = (fk == FK_JUMP) || (fk == FK_CALL) || (fk == FK_RTI);
        enter     = fetch_valid && f_entry &&
                    ((fk == FK_SEQ) || (fk == FK_JUMP) || (fk == FK_CALL));
        rti_back  = fetch_valid && (fk == FK_RTI) && !st_q.kmode && st_q.nest;
        rti_ok    = rti_back && (fetch_addr == st_q.sv_addr) &&
                    (fetch_ovl == st_q.sv_ovl);

        // Rule priority: bad return, nested vector, program space, claim, data space
        if (rti_back && !rti_ok)
            code = CZ_RTI;
        else if (fetch_valid && (fk == FK_IRQ) && st_q.kmode && st_q.nest && !f_kernel)
            code = CZ_NEST;
        else if (fetch_valid && !st_q.kmode && f_kspace && !rti_ok)
            code = CZ_PM;
        else if (!st_q.kmode && ((fetch_valid && f_claimed) || (dm_valid && d_claimed)))
            code = CZ_CLAIM;
        else if (!st_q.kmode && dm_valid && d_kspace)
            code = CZ_DM;
        else
            code = CZ_NONE;

        viol     = (code != CZ_NONE) && !busy;
        claim_wr = claim_we && st_q.kmode && !busy;

        st_d = st_q;
        if (busy) begin
            st_d = st_q;
        end else if (viol) begin
            st_d.kmode   = 1'b0;
            st_d.nest    = 1'b0;
            st_d.inh     = 1'b0;
            st_d.sv_addr = '0;
            st_d.sv_ovl  = '0;
            if (st_q.cause == 3'd0) st_d.cause = code;
        end else begin
            if (st_q.kmode) begin
                if (inh_we) st_d.inh = inh_val;
                if (fetch_valid && (fk == FK_IRQ)) begin
                    if (!st_q.nest) begin
                        st_d.sv_addr = int_addr;
                        st_d.sv_ovl  = int_ovl;
                        st_d.nest    = 1'b1;
                        st_d.kmode   = f_kernel;
                    end
                end else if (fetch_valid && is_branch && !f_kernel) begin
                    st_d.kmode = 1'b0;
                end
            end else begin
                if (enter) begin
                    st_d.kmode = 1'b1;
                end else if (rti_ok) begin
                    st_d.kmode = 1'b1;
                    st_d.nest  = 1'b0;
                end
            end
            if (!st_d.kmode) st_d.inh = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign kernel_mode = st_q.kmode;
    assign emu_gnt     = emu_req && !st_q.kmode && !busy;
    assign irq_allow   = !st_q.inh && !busy;
    assign viol_reset  = busy;
    assign erase_en    = busy;
    assign cause_valid = (st_q.cause != 3'd0) && !busy;
    assign cause       = busy ? 3'd0 : st_q.cause;
endmodule

// File: rtl/kmg_checker.sv
module kmg_checker #(
    parameter int AW         = 14,
    parameter int OVLW       = 4,
    parameter int EW         = 6,
    parameter int ENTRY_ADDR = 'h2000,
    parameter int KOVL       = 'hF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [2:0]      fetch_kind,
    input logic [AW-1:0]   fetch_addr,
    input logic [OVLW-1:0] fetch_ovl,
    input logic            kernel_mode,
    input logic            emu_gnt,
    input logic            irq_allow,
    input logic            viol_reset,
    input logic            erase_en,
    input logic [EW-1:0]   erase_addr,
    input logic            cause_valid,
    input logic [2:0]      cause
);
    p_emu_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_mode |-> !emu_gnt);

    p_reset_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_reset == erase_en);

    p_erase_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> !kernel_mode);

    p_erase_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_en) |-> (erase_addr == '0));

    p_erase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && $past(erase_en)) |-> (erase_addr == $past(erase_addr) + 1'b1));

    p_cause_hidden_r12: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> (!cause_valid && cause == 3'd0));

    p_cause_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_valid && $past(cause_valid)) |-> $stable(cause));

    p_entry_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kernel_mode) |-> ($past(fetch_valid) &&
            (($past(fetch_addr) == AW'(ENTRY_ADDR) && $past(fetch_ovl) == OVLW'(KOVL))
             || $past(fetch_kind) == 3'd3)));

    p_user_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_mode && !erase_en) |-> irq_allow);
endmodule

bind kmode_guard kmg_checker #(
    .AW(AW), .OVLW(OVLW), .EW(EW), .ENTRY_ADDR(ENTRY_ADDR), .KOVL(KOVL)
) i_kmg_checker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_kind(fetch_kind),
    .fetch_addr(fetch_addr), .fetch_ovl(fetch_ovl), .kernel_mode(kernel_mode),
    .emu_gnt(emu_gnt), .irq_allow(irq_allow), .viol_reset(viol_reset),
    .erase_en(erase_en), .erase_addr(erase_addr), .cause_valid(cause_valid),
    .cause(cause)
);

// File: tb/test_kmode_guard.sv
module test_kmode_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 6;
    localparam int EW         = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 0;
    logic [2:0] fetch_kind = 0;
    logic [13:0] fetch_addr = 0;
    logic [3:0] fetch_ovl = 0;
    logic [13:0] int_addr = 0;
    logic [3:0] int_ovl = 0;
    logic dm_valid = 0;
    logic [13:0] dm_addr = 0;
    logic [3:0] dm_ovl = 0;
    logic claim_we = 0, claim_pm = 0, claim_set = 0;
    logic [3:0] claim_blk = 0;
    logic inh_we = 0, inh_val = 0, emu_req = 0;
    logic kernel_mode, emu_gnt, irq_allow, viol_reset, erase_en, cause_valid;
    logic [EW-1:0] erase_addr;
    logic [2:0] cause;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kmode_guard #(.ERASE_WORDS(NW)) i_kmode_guard (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_kind(fetch_kind),
        .fetch_addr(fetch_addr), .fetch_ovl(fetch_ovl), .int_addr(int_addr),
        .int_ovl(int_ovl), .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_ovl(dm_ovl),
        .claim_we(claim_we), .claim_pm(claim_pm), .claim_blk(claim_blk),
        .claim_set(claim_set), .inh_we(inh_we), .inh_val(inh_val), .emu_req(emu_req),
        .kernel_mode(kernel_mode), .emu_gnt(emu_gnt), .irq_allow(irq_allow),
        .viol_reset(viol_reset), .erase_en(erase_en), .erase_addr(erase_addr),
        .cause_valid(cause_valid), .cause(cause)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        fetch_valid = 0; dm_valid = 0; claim_we = 0; inh_we = 0; emu_req = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic fetch(input int kind, input int addr, input int ovl);
        fetch_valid = 1; fetch_kind = 3'(kind); fetch_addr = 14'(addr); fetch_ovl = 4'(ovl);
        tick();
        fetch_valid = 0;
    endtask

    task automatic irq(input int vec, input int vovl, input int ia, input int iovl);
        int_addr = 14'(ia); int_ovl = 4'(iovl);
        fetch(4, vec, vovl);
    endtask

    task automatic data(input int addr, input int ovl);
        dm_valid = 1; dm_addr = 14'(addr); dm_ovl = 4'(ovl);
        tick();
        dm_valid = 0;
    endtask

    task automatic no_viol(input string req, input string what);
        check(req, int'(viol_reset), 0, what);
    endtask

    // Called in the cycle after the violating input; walks the whole erase.
    task automatic erase_walk(input string req, input int code);
        check("R11", int'(viol_reset), 1, "reset raised");
        for (int i = 0; i < NW; i++) begin
            check("R11", int'(erase_addr), i, "erase address");
            check("R12", int'(cause_valid), 0, "cause hidden during erase");
            check("R6", int'(emu_gnt), 0, "no grant during erase");
            tick();
        end
        check("R11", int'(erase_en), 0, "erase ends");
        check("R11", int'(kernel_mode), 0, "user after erase");
        check("R12", int'(cause_valid), 1, "cause visible");
        check(req, int'(cause), code, "cause code");
    endtask

    task automatic t_reset();
        do_reset();
        emu_req = 1;
        #1;
        check("R1", int'(kernel_mode), 0, "mode after reset");
        check("R1", int'(viol_reset), 0, "reset low");
        check("R1", int'(erase_en), 0, "erase low");
        check("R1", int'(cause_valid), 0, "cause invalid");
        check("R1", int'(irq_allow), 1, "irq allowed");
        check("R1", int'(emu_gnt), 1, "grant follows request");
        emu_req = 0;
    endtask

    task automatic t_entry_exit();
        do_reset();
        fetch(1, 'h2000, 'hE);
        check("R2", int'(kernel_mode), 0, "wrong overlay no entry");
        fetch(4, 'h2000, 'hF);
        check("R2", int'(kernel_mode), 0, "vector kind no entry");
        fetch(0, 'h2000, 'hF);
        check("R2", int'(kernel_mode), 1, "sequential entry");
        emu_req = 1; #1;
        check("R6", int'(emu_gnt), 0, "grant blocked in kernel");
        fetch(0, 'h0100, 'h0);
        check("R5", int'(kernel_mode), 1, "sequential does not exit");
        inh_we = 1; inh_val = 1; tick(); inh_we = 0;
        check("R10", int'(irq_allow), 0, "inhibit set");
        fetch(1, 'h0100, 'h0);
        check("R5", int'(kernel_mode), 0, "jump out exits");
        check("R10", int'(irq_allow), 1, "inhibit cleared on exit");
        check("R6", int'(emu_gnt), 1, "grant in user");
        emu_req = 0;
        fetch(2, 'h2000, 'hF);
        check("R2", int'(kernel_mode), 1, "call entry");
        fetch(1, 'h3FFF, 'hC);
        check("R5", int'(kernel_mode), 1, "jump inside kernel space");
        fetch(3, 'h0050, 'h0);
        check("R5", int'(kernel_mode), 0, "return out exits");
        no_viol("R5", "clean exits");
    endtask

    task automatic t_pm_rule();
        do_reset();
        fetch(1, 'h3000, 'hB);
        no_viol("R3", "overlay below range");
        fetch(0, 'h2001, 'hC);
        erase_walk("R3", 1);
        do_reset();
        fetch(1, 'h3FFF, 'hF);
        erase_walk("R3", 1);
    endtask

    task automatic t_dm_rule();
        do_reset();
        data('h1800, 'hF);
        no_viol("R4", "above data range");
        data('h17FF, 'hE);
        no_viol("R4", "other data overlay");
        fetch(1, 'h2000, 'hF);
        data('h0000, 'hF);
        no_viol("R4", "kernel data access");
        fetch(1, 'h0200, 'h0);
        data('h17FF, 'hF);
        erase_walk("R4", 2);
    endtask

    task automatic t_claim();
        do_reset();
        claim_we = 1; claim_pm = 0; claim_blk = 1; claim_set = 1; tick(); claim_we = 0;
        data('h0400, 'h0);
        no_viol("R7", "user claim ignored");
        fetch(1, 'h2000, 'hF);
        claim_we = 1; tick(); claim_we = 0;
        data('h0400, 'h0);
        no_viol("R7", "kernel access to claim");
        fetch(1, 'h0200, 'h0);
        data('h0800, 'h0);
        no_viol("R7", "next block free");
        data('h07FF, 'h0);
        erase_walk("R7", 3);
        data('h0400, 'h0);
        no_viol("R7", "claims cleared by erase");
    endtask

    task automatic t_rti();
        do_reset();
        fetch(1, 'h2000, 'hF);
        irq('h0040, 'h0, 'h2345, 'hF);
        check("R8", int'(kernel_mode), 0, "user handler");
        fetch(0, 'h0041, 'h0);
        fetch(3, 'h2345, 'hF);
        check("R8", int'(kernel_mode), 1, "return to saved point");
        no_viol("R8", "matching return");
        irq('h0040, 'h0, 'h2346, 'hF);
        fetch(3, 'h2347, 'hF);
        erase_walk("R8", 5);
    endtask

    task automatic t_nest();
        do_reset();
        fetch(1, 'h2000, 'hF);
        irq('h0040, 'h0, 'h2100, 'hF);
        fetch(2, 'h2000, 'hF);
        check("R9", int'(kernel_mode), 1, "nested entry");
        irq('h2800, 'hF, 'h2010, 'hF);
        check("R9", int'(kernel_mode), 1, "kernel vector while nested");
        no_viol("R9", "kernel vector accepted");
        irq('h0060, 'h0, 'h2011, 'hF);
        erase_walk("R9", 4);
    endtask

    task automatic t_sticky();
        do_reset();
        data('h0010, 'hF);
        erase_walk("R12", 2);
        fetch(1, 'h2500, 'hD);
        check("R11", int'(viol_reset), 1, "second violation");
        for (int i = 0; i < NW; i++) tick();
        check("R12", int'(cause), 2, "first cause kept");
        check("R12", int'(cause_valid), 1, "still valid");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_entry_exit();
        t_pm_rule();
        t_dm_rule();
        t_claim();
        t_rti();
        t_nest();
        t_sticky();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule